// File: doc/BRIEF.md
# I/Q Interleaving Parallel Output Port

This block sends complex samples from up to four filter channels over one 16-bit parallel bus. Each channel has a one-entry holding register that captures a sample, an in-phase and a quadrature word, when the channel's valid strobe is high. When the port is enabled in channel mode and the receiver holds both request and acknowledge high, the port picks the next held sample and sends two words. The in-phase word goes out first, with the I/Q indicator high. The quadrature word follows on the next clock, with the indicator low. A 2-bit channel tag marks which channel each word came from.

An 8-bit control word sets the behaviour. Bit 7 enables the port. Bit 0 selects channel mode. Bits 1 to 4 choose which channels are served. With the port enabled and channel mode clear, the low byte of the bus carries an 8-bit link byte instead, and no channel words are sent. The port never drives both kinds of data in the same cycle. If a sample arrives while its channel's register is still full, the sample is dropped and a sticky overflow flag for that channel is set.

Top module: `iq_par_port`

## Requirements
- R1: After reset, `pdata` is 0, `iq_flag` is 0, `ch_tag` is 0 and `ovf` is 0.
- R2: A transfer starts at a rising edge only when all of these hold: control bit 7 is 1, control bit 0 is 1, `req` is 1, `ack` is 1, and at least one selected channel has a held sample. In the cycle after that edge, `pdata` shows the channel's in-phase word, `iq_flag` is 1 and `ch_tag` is the channel index (0 to 3).
- R3: In the cycle right after the in-phase word, `pdata` shows the same channel's quadrature word, `iq_flag` is 0 and `ch_tag` is unchanged. This happens whatever `req`, `ack` or the control word do in that cycle.
- R4: Control bit n+1 selects channel index n. A channel whose bit is clear is never sent, and its held sample is kept until the channel is selected.
- R5: Eligible channels are served in round-robin order. The search starts at the index after the last channel served and wraps from 3 to 0.
- R6: Each channel holds one sample. The sample is captured when `smp_valid` is high and the register is empty. The register is emptied in the cycle its quadrature word goes out. A sample that arrives in that same cycle is captured without overflow.
- R7: If `smp_valid` is high while the register is full and not being emptied, the corresponding `ovf` bit goes to 1 and stays 1 until reset. The new sample is dropped and the held sample is sent unchanged.
- R8: When no transfer is in progress or starting, `pdata` and `ch_tag` keep their last values and `iq_flag` is 0.
- R9: When enabled with channel mode clear, and no quadrature word is pending, `pdata` equals `{8'h00, link_byte}` one cycle later and `iq_flag` is 0. No channel words are sent, and held samples are kept.
- R10: With control bit 7 clear, and no quadrature word pending, `pdata`, `ch_tag` and `iq_flag` hold their values. Samples are still captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_ctrl | input | 8 | Control word: bit 7 enable, bit 0 channel mode, bits 1..4 channel selects |
| link_byte | input | 8 | Byte placed on the bus low byte in link mode |
| smp_valid | input | 4 | Per-channel sample strobe |
| smp_i | input | 64 | In-phase words, channel n in bits 16n+15..16n |
| smp_q | input | 64 | Quadrature words, same packing |
| req | input | 1 | Transfer request from the receiver |
| ack | input | 1 | Transfer acknowledge from the receiver |
| pdata | output | 16 | Parallel output bus |
| iq_flag | output | 1 | High while the in-phase word is on the bus |
| ch_tag | output | 2 | Channel index of the word on the bus |
| ovf | output | 4 | Sticky per-channel overflow flags |

## Verification
The bench builds the block with its defaults: four channels, 16-bit words and an 8-bit link byte. With these values every one of the 16 channel-select masks can be swept, and the expected word order is worked out in the bench from its own round-robin pointer. Because each mask is followed by a full drain, the pointer wraps from channel 3 to 0 many times, and samples left on unselected channels are checked once they are finally sent. Separate passes cover the handshake gating, a quadrature word that follows after the handshake drops, overflow, a capture in the same cycle as the register is emptied, link mode and the disabled port.

// File: rtl/iq_port_pkg.sv
package iq_port_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_QWORD = 1'b1
  } phase_e;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_SEL_LSB  = 1;
endpackage

// File: rtl/iq_hold_bank.sv
module iq_hold_bank #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    in_valid,
  input  logic [NCH*DW-1:0] in_i,
  input  logic [NCH*DW-1:0] in_q,
  input  logic [NCH-1:0]    release_ch,
  output logic [NCH-1:0]    full,
  output logic [NCH*DW-1:0] held_i,
  output logic [NCH*DW-1:0] held_q,
  output logic [NCH-1:0]    ovf
);
  for (genvar c = 0; c < NCH; c++) begin : g_slot
    logic          full_q, full_d;
    logic          ovf_q, ovf_d;
    logic          take;
    logic [DW-1:0] i_q, q_q;

    // A slot accepts when empty, or when emptied in this same cycle
    always_comb begin
      take   = in_valid[c] && (!full_q || release_ch[c]);
      full_d = full_q;
      if (take)               full_d = 1'b1;
      else if (release_ch[c]) full_d = 1'b0;
      ovf_d  = ovf_q | (in_valid[c] & full_q & ~release_ch[c]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        ovf_q  <= 1'b0;
      end else begin
        full_q <= full_d;
        ovf_q  <= ovf_d;
      end
    end

    // Data path: enable-gated, no reset needed
    always_ff @(posedge clk) begin
      if (take) begin
        i_q <= in_i[c*DW +: DW];
        q_q <= in_q[c*DW +: DW];
      end
    end

    assign full[c]            = full_q;
    assign ovf[c]             = ovf_q;
    assign held_i[c*DW +: DW] = i_q;
    assign held_q[c*DW +: DW] = q_q;
  end
endmodule

// File: rtl/iq_rr_pick.sv
module iq_rr_pick #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  input  logic [CHW-1:0] start_at,
  output logic           found,
  output logic [CHW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < NCH; k++) begin
      if (!found && elig[(int'(start_at) + k) % NCH]) begin
        found = 1'b1;
        pick  = CHW'((int'(start_at) + k) % NCH);
      end
    end
  end
endmodule

// File: rtl/iq_par_port.sv
module iq_par_port
  import iq_port_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DW    = 16,
  parameter int LW    = 8,
  parameter int CTRLW = 8,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRLW-1:0]  cfg_ctrl,
  input  logic [LW-1:0]     link_byte,
  input  logic [NCH-1:0]    smp_valid,
  input  logic [NCH*DW-1:0] smp_i,
  input  logic [NCH*DW-1:0] smp_q,
  input  logic              req,
  input  logic              ack,
  output logic [DW-1:0]     pdata,
  output logic              iq_flag,
  output logic [CHW-1:0]    ch_tag,
  output logic [NCH-1:0]    ovf
);
  phase_e             phase_q, phase_d;
  logic [CHW-1:0]     cur_q, cur_d;
  logic [CHW-1:0]     ptr_q, ptr_d;
  logic [DW-1:0]      pdata_q, pdata_d;
  logic               iq_q, iq_d;
  logic [CHW-1:0]     tag_q, tag_d;
  logic               out_en;

  logic [NCH-1:0]     full, elig, release_ch;
  logic [NCH*DW-1:0]  held_i, held_q;
  logic               any_elig, start, link_act, port_en, chan_mode;
  logic [CHW-1:0]     pick;

  assign port_en   = cfg_ctrl[CTRL_EN_BIT];
  assign chan_mode = cfg_ctrl[CTRL_MODE_BIT];
  assign elig      = full & cfg_ctrl[CTRL_SEL_LSB +: NCH];

  iq_hold_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (smp_valid),
    .in_i       (smp_i),
    .in_q       (smp_q),
    .release_ch (release_ch),
    .full       (full),
    .held_i     (held_i),
    .held_q     (held_q),
    .ovf        (ovf)
  );

  iq_rr_pick #(.NCH(NCH)) u_pick (
    .elig     (elig),
    .start_at (ptr_q),
    .found    (any_elig),
    .pick     (pick)
  );

  assign start    = (phase_q == PH_IDLE) && port_en && chan_mode && req && ack && any_elig;
  assign link_act = (phase_q == PH_IDLE) && port_en && !chan_mode;
  assign out_en   = start || link_act || (phase_q == PH_QWORD);

  // Next-state logic
  always_comb begin
    phase_d    = phase_q;
    cur_d      = cur_q;
    ptr_d      = ptr_q;
    pdata_d    = pdata_q;
    iq_d       = iq_q;
    tag_d      = tag_q;
    release_ch = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          pdata_d = held_i[int'(pick)*DW +: DW];
          iq_d    = 1'b1;
          tag_d   = pick;
          cur_d   = pick;
          phase_d = PH_QWORD;
        end else if (link_act) begin
          pdata_d = {{(DW-LW){1'b0}}, link_byte};
          iq_d    = 1'b0;
        end
      end
      PH_QWORD: begin
        pdata_d           = held_q[int'(cur_q)*DW +: DW];
        iq_d              = 1'b0;
        release_ch[cur_q] = 1'b1;
        ptr_d             = (int'(cur_q) == NCH-1) ? '0 : cur_q + 1'b1;
        phase_d           = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // Sequencing registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cur_q   <= '0;
      ptr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cur_q   <= cur_d;
      ptr_q   <= ptr_d;
    end
  end

  // Output registers, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdata_q <= '0;
      iq_q    <= 1'b0;
      tag_q   <= '0;
    end else if (out_en) begin
      pdata_q <= pdata_d;
      iq_q    <= iq_d;
      tag_q   <= tag_d;
    end
  end

  assign pdata   = pdata_q;
  assign iq_flag = iq_q;
  assign ch_tag  = tag_q;
endmodule

// File: rtl/iq_par_port_chk.sv
module iq_par_port_chk #(
  parameter int NCH   = 4,
  parameter int DW    = 16,
  parameter int LW    = 8,
  parameter int CTRLW = 8,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CTRLW-1:0] cfg_ctrl,
  input logic             req,
  input logic             ack,
  input logic [DW-1:0]    pdata,
  input logic             iq_flag,
  input logic [CHW-1:0]   ch_tag,
  input logic [NCH-1:0]   ovf
);
  assert_i_needs_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iq_flag |-> $past(req && ack && cfg_ctrl[7] && cfg_ctrl[0]));

  assert_q_follows_i_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iq_flag |=> (!iq_flag && $stable(ch_tag)));

  assert_sel_respected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iq_flag |-> (|(($past(cfg_ctrl) >> (32'(ch_tag) + 1)) & CTRLW'(1))));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf & $past(ovf)) == $past(ovf)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!(req && ack)) && $past(cfg_ctrl[0]) && !$past(iq_flag))
      |-> ($stable(pdata) && $stable(ch_tag) && !iq_flag));

  assert_link_low_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_ctrl[7] && !cfg_ctrl[0]) && !$past(iq_flag))
      |-> ((pdata >> LW) == '0 && !iq_flag));

  assert_disabled_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_ctrl[7]) && !$past(iq_flag))
      |-> ($stable(pdata) && $stable(ch_tag) && !iq_flag));
endmodule

bind iq_par_port iq_par_port_chk #(
  .NCH(NCH), .DW(DW), .LW(LW), .CTRLW(CTRLW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_ctrl (cfg_ctrl),
  .req      (req),
  .ack      (ack),
  .pdata    (pdata),
  .iq_flag  (iq_flag),
  .ch_tag   (ch_tag),
  .ovf      (ovf)
);

// File: tb/iq_par_port_bench.sv
module iq_par_port_bench;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [7:0]        cfg_ctrl;
  logic [7:0]        link_byte;
  logic [NCH-1:0]    smp_valid;
  logic [NCH*DW-1:0] smp_i, smp_q;
  logic              req, ack;
  logic [DW-1:0]     pdata;
  logic              iq_flag;
  logic [1:0]        ch_tag;
  logic [NCH-1:0]    ovf;

  int checks = 0;
  int fails  = 0;

  // Bench-side model state
  logic [3:0]  pend;
  logic [15:0] iv [4];
  logic [15:0] qv [4];
  int          ptr;
  logic [15:0] last;

  always #10 clk = ~clk;

  iq_par_port u_iq_par_port (
    .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .link_byte(link_byte),
    .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q), .req(req), .ack(ack),
    .pdata(pdata), .iq_flag(iq_flag), .ch_tag(ch_tag), .ovf(ovf)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_i(input int c, input int t);
    return 16'((c + 1) * 16'h1000 + t * 16 + 5);
  endfunction

  // Drive one sample strobe; upd=0 leaves the bench model untouched
  task automatic load(input int c, input logic [15:0] iw, input logic [15:0] qw, input bit upd);
    smp_valid[c]        = 1'b1;
    smp_i[c*DW +: DW]   = iw;
    smp_q[c*DW +: DW]   = qw;
    @(negedge clk);
    smp_valid = '0;
    if (upd) begin
      pend[c] = 1'b1;
      iv[c]   = iw;
      qv[c]   = qw;
    end
  endtask

  task automatic serve(input logic [3:0] sel);
    int p;
    cfg_ctrl = 8'h81 | {3'b000, sel, 1'b0};
    req = 1'b1;
    ack = 1'b1;
    while ((pend & sel) != 0) begin
      p = -1;
      for (int k = 0; k < 4; k++)
        if (p < 0 && pend[(ptr + k) % 4] && sel[(ptr + k) % 4]) p = (ptr + k) % 4;
      @(negedge clk);
      chk("R2 R5 in-phase word", pdata, iv[p]);
      chk("R2 iq flag high", iq_flag, 1);
      chk("R4 R5 channel tag", ch_tag, p);
      @(negedge clk);
      chk("R3 quadrature word", pdata, qv[p]);
      chk("R3 iq flag low", iq_flag, 0);
      chk("R3 tag unchanged", ch_tag, p);
      pend[p] = 1'b0;
      ptr     = (p + 1) % 4;
      last    = qv[p];
    end
    @(negedge clk);
    chk("R8 idle hold data", pdata, last);
    chk("R8 idle iq low", iq_flag, 0);
    req = 1'b0;
    ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_ctrl = '0; link_byte = '0; smp_valid = '0;
    smp_i = '0; smp_q = '0; req = 1'b0; ack = 1'b0;
    pend = '0; ptr = 0; last = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pdata", pdata, 0);
    chk("R1 reset iq", iq_flag, 0);
    chk("R1 reset tag", ch_tag, 0);
    chk("R1 reset ovf", ovf, 0);

    // Sweep every select mask, then drain leftovers with all selected
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 4; c++) load(c, mk_i(c, m), ~mk_i(c, m), 1'b1);
      serve(4'(m));
      chk("R4 unselected still held", pend, ~4'(m) & 4'hF);
      serve(4'hF);
      chk("R6 no overflow in sweep", ovf, 0);
    end

    // Handshake gating
    cfg_ctrl = 8'h9F;
    load(2, 16'hA2A2, 16'h5D5D, 1'b1);
    req = 1'b1; ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 no start without ack", iq_flag, 0);
    chk("R2 R8 data held without ack", pdata, last);
    req = 1'b0; ack = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 no start without req", iq_flag, 0);
    chk("R2 R8 data held without req", pdata, last);
    req = 1'b1;
    @(negedge clk);
    chk("R2 start on handshake", pdata, 16'hA2A2);
    req = 1'b0; ack = 1'b0;
    @(negedge clk);
    chk("R3 Q after handshake drop", pdata, 16'h5D5D);
    chk("R3 tag after handshake drop", ch_tag, 2);
    pend[2] = 1'b0; ptr = 3; last = 16'h5D5D;
    @(negedge clk);
    chk("R8 hold after Q", pdata, last);
    chk("R8 iq low after Q", iq_flag, 0);

    // Disabled port: outputs frozen, capture continues
    cfg_ctrl = 8'h1F; req = 1'b1; ack = 1'b1;
    load(1, 16'h1357, 16'h2468, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10 disabled data hold", pdata, last);
    chk("R10 disabled iq low", iq_flag, 0);
    req = 1'b0; ack = 1'b0;
    serve(4'hF);

    // Link mode
    load(0, 16'h0F0F, 16'hF0F0, 1'b1);
    load(3, 16'h3C3C, 16'hC3C3, 1'b1);
    cfg_ctrl = 8'h9E; req = 1'b1; ack = 1'b1;
    link_byte = 8'h5A;
    @(negedge clk);
    chk("R9 link byte on bus", pdata, 16'h005A);
    chk("R9 link iq low", iq_flag, 0);
    link_byte = 8'hC3;
    @(negedge clk);
    chk("R9 link byte follows", pdata, 16'h00C3);
    last = 16'h00C3;
    req = 1'b0; ack = 1'b0;
    chk("R9 samples kept in link mode", pend, 4'b1001);
    serve(4'hF);

    // Overflow: second sample dropped, first kept, flag sticky
    cfg_ctrl = 8'h00;
    load(0, 16'hAAAA, 16'h5555, 1'b1);
    load(0, 16'hBBBB, 16'h4444, 1'b0);
    chk("R7 overflow flag set", ovf, 4'b0001);
    serve(4'hF);
    chk("R7 overflow sticky", ovf, 4'b0001);

    // Capture in the same cycle the slot is emptied
    load(2, 16'h7777, 16'h8888, 1'b1);
    cfg_ctrl = 8'h89; req = 1'b1; ack = 1'b1;
    @(negedge clk);
    chk("R6 first sample I", pdata, 16'h7777);
    smp_valid[2] = 1'b1; smp_i[2*DW +: DW] = 16'h9999; smp_q[2*DW +: DW] = 16'h6666;
    @(negedge clk);
    smp_valid = '0;
    chk("R6 first sample Q", pdata, 16'h8888);
    @(negedge clk);
    chk("R6 same-cycle capture I", pdata, 16'h9999);
    @(negedge clk);
    chk("R6 same-cycle capture Q", pdata, 16'h6666);
    chk("R6 R7 no new overflow", ovf, 4'b0001);
    req = 1'b0; ack = 1'b0;
    pend[2] = 1'b0; ptr = 3;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule